// File: doc/BRIEF.md
# Floating-Exponent Input Scaler with Second-Order CIC Decimator

This block is the first stage of a digital receive path. Each input sample carries an in-phase and a quadrature mantissa that share one 3-bit exponent. The block turns each mantissa into a fixed-point word. The total shift is the sample's exponent plus a programmed 3-bit offset. A programmed direction bit decides whether that shift moves the data up or down. Shifts upward saturate at the width of the fixed-point datapath.

After conversion, the word is moved down by a pre-scale of 0 to 6 bits. The pre-scale keeps the integrators from wrapping in two's complement, since a wrap would show up as spectral errors. The scaled word then goes through a second-order cascaded integrator-comb decimator. The two integrators run at the input rate and the two combs run at the decimated rate. The I and Q lanes use identical hardware and share one decimation phase.

A host configures the block through two byte-wide registers, and both can be read back. One register holds the scale and exponent controls. The other holds the decimation rate minus one.

Top module: `expcic2_front`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0, `out_i`/`out_q` are 0, and both registers read 0.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata` in the control register, and a write with `cfg_sel`=1 stores it in the decimation register. `cfg_rdata` returns the register that `cfg_sel` selects in the following cycle. A write affects samples presented from the next cycle on.
- R3: Control bits [7:5] hold an offset `off` and bit 4 holds the direction `up`. With `up`=0, the fixed-point value is the mantissa, sign-extended to FP_W bits and shifted arithmetically right by `exp+off`.
- R4: With `up`=1, the fixed-point value is the mantissa multiplied by 2^(exp+off). If the result leaves the signed FP_W range, it saturates to the most positive or most negative FP_W value.
- R5: Control bits [2:0] hold the pre-scale `pre`. The fixed-point value is shifted arithmetically right by `pre` bits before integration. Values 7 act as 6.
- R6: The decimation rate is min(decim register, 15)+1. One output strobe occurs for every rate samples taken into the integrators.
- R7: Each lane's output equals two cascaded integrators (the second integrator adds the first integrator's previous value), followed by two first-difference combs at the decimated rate. All arithmetic is modulo 2^ACC_W, with ACC_W = FP_W + 2·log2(16). `out_i`/`out_q` change only together with `out_valid`.
- R8: A sample presented with `in_valid` in cycle t enters the integrators at the second rising edge. If it completes a decimation period, `out_valid` is high in cycle t+2.
- R9: A write to the decimation register restarts the decimation phase. A sample integrated on that same edge is kept, but it produces no strobe, and the next sample integrated is the first one of a new period.
- R10: With no input samples, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_i | input | MANT_W | In-phase mantissa, two's complement |
| in_q | input | MANT_W | Quadrature mantissa, two's complement |
| in_exp | input | 3 | Shared exponent |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = decimation register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| out_valid | output | 1 | Decimated output strobe |
| out_i | output | ACC_W | In-phase filter output |
| out_q | output | ACC_W | Quadrature filter output |

## Verification
The delicate coincidence is a write to the decimation register landing on the same edge as a sample that would otherwise close a decimation period. On that edge, integration and the phase restart compete. The bench provokes this by writing the register during an unbroken stream of samples at several phases. A behavioural model applies the rule that the sample is integrated but no strobe occurs. Every following strobe position and output value is compared against that model on each clock. A second overlap, a control write during a live sample, is judged the same way: the sample in flight must still use the old scaling.

// File: rtl/expcic2_pkg.sv
package expcic2_pkg;

   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_DECIM = 1'b1
   } cfg_sel_e;

   // control register layout: [7:5] offset, [4] direction, [3] spare, [2:0] pre-scale
   typedef struct packed {
      logic [2:0] off;
      logic       up;
      logic       spare;
      logic [2:0] pre;
   } ctrl_t;

   localparam int unsigned PRE_MAX = 6;
   localparam int unsigned SH_MAX  = 14;

endpackage

// File: rtl/exp_scaler.sv
module exp_scaler
   import expcic2_pkg::*;
#(
   parameter int MANT_W   = 12,
   parameter int FP_W     = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [MANT_W-1:0] mant,
   input  logic [2:0]               exp_i,
   input  ctrl_t                    ctrl,
   output logic signed [FP_W-1:0]   fx
);
   localparam int WIDE_W = FP_W + SH_MAX;

   logic [3:0]               sh;
   logic [2:0]               pre_eff;
   logic signed [WIDE_W-1:0] mant_w;
   logic signed [WIDE_W-1:0] up_w;
   logic signed [FP_W-1:0]   mant_f;
   logic signed [FP_W-1:0]   up_fx;
   logic signed [FP_W-1:0]   dn_fx;
   logic signed [FP_W-1:0]   sel_fx;

   assign sh      = {1'b0, exp_i} + {1'b0, ctrl.off};
   assign pre_eff = (ctrl.pre > 3'(PRE_MAX)) ? 3'(PRE_MAX) : ctrl.pre;
   assign mant_w  = WIDE_W'(mant);
   assign mant_f  = FP_W'(mant);
   assign up_w    = mant_w <<< sh;
   assign dn_fx   = mant_f >>> sh;

   generate
      if (SATURATE) begin : g_sat
         logic fits;
         assign fits = (up_w[WIDE_W-1:FP_W-1] == '0) || (up_w[WIDE_W-1:FP_W-1] == '1);
         always_comb begin
            if (fits)             up_fx = up_w[FP_W-1:0];
            else if (up_w[WIDE_W-1]) up_fx = {1'b1, {(FP_W-1){1'b0}}};
            else                  up_fx = {1'b0, {(FP_W-1){1'b1}}};
         end
      end else begin : g_wrap
         assign up_fx = up_w[FP_W-1:0];
      end
   endgenerate

   assign sel_fx = ctrl.up ? up_fx : dn_fx;
   assign fx     = sel_fx >>> pre_eff;

endmodule

// File: rtl/decim_ctrl.sv
module decim_ctrl #(
   parameter int RATE_MAX = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       step,
   input  logic       restart,
   input  logic [7:0] rm1_reg,
   output logic       fire
);
   localparam int         CNT_W   = $clog2(RATE_MAX);
   localparam logic [7:0] RM1_LIM = 8'(RATE_MAX - 1);

   logic [CNT_W-1:0] cnt;
   logic [7:0]       rm1_clip;
   logic [CNT_W-1:0] rm1_eff;

   assign rm1_clip = (rm1_reg > RM1_LIM) ? RM1_LIM : rm1_reg;
   assign rm1_eff  = rm1_clip[CNT_W-1:0];
   assign fire     = step && !restart && (cnt == rm1_eff);

   always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (restart) cnt <= '0;
      else if (step)    cnt <= fire ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/cic2_lane.sv
module cic2_lane #(
   parameter int FP_W  = 16,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    step,
   input  logic                    fire,
   input  logic signed [FP_W-1:0]  x,
   output logic signed [ACC_W-1:0] y
);
   logic signed [ACC_W-1:0] int1, int2, dly1, dly2;
   logic signed [ACC_W-1:0] x_ext, int1_n, int2_n, comb1, comb2;

   assign x_ext  = ACC_W'(x);
   assign int1_n = int1 + x_ext;
   assign int2_n = int2 + int1;
   assign comb1  = int2_n - dly1;
   assign comb2  = comb1 - dly2;

   always_ff @(posedge clk) begin
      if (rst) begin
         int1 <= '0;
         int2 <= '0;
         dly1 <= '0;
         dly2 <= '0;
         y    <= '0;
      end else begin
         if (step) begin
            int1 <= int1_n;
            int2 <= int2_n;
         end
         if (fire) begin
            dly1 <= int2_n;
            dly2 <= comb1;
            y    <= comb2;
         end
      end
   end

endmodule

// File: rtl/expcic2_front.sv
module expcic2_front
   import expcic2_pkg::*;
#(
   parameter int MANT_W   = 12,
   parameter int FP_W     = 16,
   parameter int RATE_MAX = 16,
   parameter bit SATURATE = 1'b1,
   localparam int ACC_W   = FP_W + 2 * $clog2(RATE_MAX)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [MANT_W-1:0] in_i,
   input  logic [MANT_W-1:0] in_q,
   input  logic [2:0]        in_exp,
   input  logic              cfg_wr_en,
   input  logic              cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_i,
   output logic [ACC_W-1:0]  out_q
);
   localparam int LANES = 2;

   if (FP_W <= MANT_W) begin : g_bad_fp
      $error("FP_W must exceed MANT_W");
   end
   if (RATE_MAX < 2 || RATE_MAX > 256) begin : g_bad_rate
      $error("RATE_MAX must lie in 2..256");
   end

   ctrl_t      ctrl_q;
   logic [7:0] decim_q;
   logic       ctrl_wr, decim_wr;
   logic       s1_val;
   logic       fire;

   logic signed [MANT_W-1:0] mant [LANES];
   logic signed [ACC_W-1:0]  y    [LANES];

   assign ctrl_wr   = cfg_wr_en && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
   assign decim_wr  = cfg_wr_en && (cfg_sel_e'(cfg_sel) == SEL_DECIM);
   assign cfg_rdata = (cfg_sel_e'(cfg_sel) == SEL_DECIM) ? decim_q : ctrl_q;
   assign mant[0]   = in_i;
   assign mant[1]   = in_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q    <= '0;
         decim_q   <= '0;
         s1_val    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         if (ctrl_wr)  ctrl_q  <= ctrl_t'(cfg_wdata);
         if (decim_wr) decim_q <= cfg_wdata;
         s1_val    <= in_valid;
         out_valid <= fire;
      end
   end

   decim_ctrl #(.RATE_MAX(RATE_MAX)) u_decim (
      .clk     (clk),
      .rst     (rst),
      .step    (s1_val),
      .restart (decim_wr),
      .rm1_reg (decim_q),
      .fire    (fire)
   );

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic signed [FP_W-1:0] fx;
      logic signed [FP_W-1:0] s1_x;

      exp_scaler #(.MANT_W(MANT_W), .FP_W(FP_W), .SATURATE(SATURATE)) u_scale (
         .mant  (mant[ln]),
         .exp_i (in_exp),
         .ctrl  (ctrl_q),
         .fx    (fx)
      );

      always_ff @(posedge clk) begin
         if (rst) s1_x <= '0;
         else     s1_x <= fx;
      end

      cic2_lane #(.FP_W(FP_W), .ACC_W(ACC_W)) u_cic (
         .clk  (clk),
         .rst  (rst),
         .step (s1_val),
         .fire (fire),
         .x    (s1_x),
         .y    (y[ln])
      );
   end

   assign out_i = y[0];
   assign out_q = y[1];

endmodule

// File: rtl/expcic2_front_chk.sv
module expcic2_front_chk #(
   parameter int ACC_W = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             cfg_wr_en,
   input logic             cfg_sel,
   input logic [7:0]       cfg_wdata,
   input logic [7:0]       cfg_rdata,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_i,
   input logic [ACC_W-1:0] out_q
);
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);

   assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 2));

   assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg_wr_en) && !$past(cfg_sel) && !$past(rst) && !cfg_wr_en && !cfg_sel)
      |-> cfg_rdata == $past(cfg_wdata));

   assert_decim_readback_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg_wr_en) && $past(cfg_sel) && !$past(rst) && !cfg_wr_en && cfg_sel)
      |-> cfg_rdata == $past(cfg_wdata));

   assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind expcic2_front expcic2_front_chk #(.ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .cfg_wr_en (cfg_wr_en),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q)
);

// File: tb/expcic2_front_bench.sv
module expcic2_front_bench;
   localparam int MANT_W = 12;
   localparam int FP_W   = 16;
   localparam int ACC_W  = FP_W + 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [MANT_W-1:0] in_i = '0, in_q = '0;
   logic [2:0]        in_exp = '0;
   logic              cfg_wr_en = 1'b0, cfg_sel = 1'b0;
   logic [7:0]        cfg_wdata = '0;
   logic [7:0]        cfg_rdata;
   logic              out_valid;
   logic [ACC_W-1:0]  out_i, out_q;

   int    n_checks = 0, n_fail = 0;
   string phase = "R1";
   bit    done = 0;

   always #2.5 clk = ~clk;

   expcic2_front u_expcic2_front (.*);

   // behavioural reference model
   longint m_i1 [2], m_i2 [2], m_d1 [2], m_d2 [2], m_y [2], m_s1x [2];
   bit     m_s1v, m_outv;
   int     m_cnt;
   int     m_ctrl, m_dec;

   function automatic longint wrap(longint v);
      longint m = v & ((64'sd1 <<< ACC_W) - 1);
      if (m[ACC_W-1]) m = m - (64'sd1 <<< ACC_W);
      return m;
   endfunction

   function automatic longint scale(logic [MANT_W-1:0] raw, int e, int ctrl);
      longint v   = longint'($signed(raw));
      int     s   = e + ((ctrl >> 5) & 7);
      int     pre = ctrl & 7;
      longint hi  = (64'sd1 <<< (FP_W-1)) - 1;
      longint lo  = -(64'sd1 <<< (FP_W-1));
      if (pre > 6) pre = 6;
      if ((ctrl >> 4) & 1) begin
         v = v * (64'sd1 <<< s);
         if (v > hi) v = hi;
         if (v < lo) v = lo;
      end else begin
         v = v >>> s;
      end
      return v >>> pre;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < 2; k++) begin
            m_i1[k] = 0; m_i2[k] = 0; m_d1[k] = 0; m_d2[k] = 0; m_y[k] = 0; m_s1x[k] = 0;
         end
         m_s1v = 0; m_outv = 0; m_cnt = 0; m_ctrl = 0; m_dec = 0;
      end else begin
         int  rm1;
         bit  dw, fire;
         rm1  = (m_dec > 15) ? 15 : m_dec;
         dw   = cfg_wr_en && cfg_sel;
         fire = m_s1v && !dw && (m_cnt == rm1);
         for (int k = 0; k < 2; k++) begin
            if (m_s1v) begin
               longint n1, n2, c1;
               n1 = wrap(m_i1[k] + m_s1x[k]);
               n2 = wrap(m_i2[k] + m_i1[k]);
               if (fire) begin
                  c1 = wrap(n2 - m_d1[k]);
                  m_y[k]  = wrap(c1 - m_d2[k]);
                  m_d1[k] = n2;
                  m_d2[k] = c1;
               end
               m_i1[k] = n1;
               m_i2[k] = n2;
            end
         end
         m_outv = fire;
         if (dw)         m_cnt = 0;
         else if (m_s1v) m_cnt = fire ? 0 : m_cnt + 1;
         m_s1v    = in_valid;
         m_s1x[0] = scale(in_i, int'(in_exp), m_ctrl);
         m_s1x[1] = scale(in_q, int'(in_exp), m_ctrl);
         if (cfg_wr_en && !cfg_sel) m_ctrl = int'(cfg_wdata);
         if (dw)                    m_dec  = int'(cfg_wdata);
      end
   end

   task automatic check(string req, longint act, longint exp_v);
      n_checks++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s (%s): actual %0d expected %0d at %0t", req, phase, act, exp_v, $time);
      end
   endtask

   task automatic compare();
      check("R6 R8 R10 out_valid", longint'(out_valid), longint'(m_outv));
      check("R7 out_i", longint'($signed(out_i)), m_y[0]);
      check("R7 out_q", longint'($signed(out_q)), m_y[1]);
      check("R2 cfg_rdata", longint'(cfg_rdata), cfg_sel ? longint'(m_dec) : longint'(m_ctrl));
   endtask

   task automatic tick(bit v, bit wr, bit sel, int wd);
      @(negedge clk);
      compare();
      in_valid  = v;
      in_i      = MANT_W'($urandom);
      in_q      = MANT_W'($urandom);
      in_exp    = 3'($urandom);
      cfg_wr_en = wr;
      cfg_sel   = wr ? sel : 1'($urandom);
      cfg_wdata = 8'(wd);
   endtask

   task automatic run(int n, int pct);
      for (int c = 0; c < n; c++) tick(($urandom % 100) < pct, 1'b0, 1'b0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      phase = "R1";
      check("R1 out_valid in reset", longint'(out_valid), 0);
      check("R1 rdata in reset", longint'(cfg_rdata), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 out_valid after reset", longint'(out_valid), 0);
      check("R1 out_i after reset", longint'(out_i), 0);

      // R3: downward exponent, offset 2, rate 4
      phase = "R3";
      tick(1'b0, 1'b1, 1'b0, 8'b010_0_0_000);
      tick(1'b0, 1'b1, 1'b1, 3);
      run(60, 70);

      // R4: upward exponent with saturation, rate 1
      phase = "R4";
      tick(1'b1, 1'b1, 1'b0, 8'b011_1_0_001);
      tick(1'b1, 1'b1, 1'b1, 0);
      run(40, 100);

      // R5: pre-scale 7 behaves as 6, rate 8
      phase = "R5";
      tick(1'b1, 1'b1, 1'b0, 8'b000_0_0_111);
      tick(1'b1, 1'b1, 1'b1, 7);
      run(60, 80);
      tick(1'b1, 1'b1, 1'b0, 8'b001_1_0_011);
      run(40, 90);

      // R6: oversize decimation register clamps to rate 16
      phase = "R6";
      tick(1'b1, 1'b1, 1'b1, 200);
      run(120, 100);
      tick(1'b1, 1'b1, 1'b1, 5);
      run(50, 60);

      // R9: decimation writes landing on live samples at varied phases
      phase = "R9";
      for (int w = 0; w < 8; w++) begin
         tick(1'b1, 1'b1, 1'b1, 2 + (w % 3));
         for (int c = 0; c < w + 2; c++) tick(1'b1, 1'b0, 1'b0, 0);
      end
      run(30, 100);

      // R10: no samples, no strobes
      phase = "R10";
      run(30, 0);

      @(negedge clk);
      compare();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule